// File: doc/BRIEF.md
# ATA Task-File Shadow Register Block

This block is the device-side copy of the ATA command block registers. A host writes one byte at a time: a register-select code, a data byte and a write strobe. The address bytes, the sector count and the feature register each keep the byte just written and the byte written before it. The block joins each pair into a wide field: a 48-bit block address, a 16-bit count and a 16-bit feature value. For 28-bit addressing it also gives an address whose top nibble comes from the device register.

It also holds the device register and decodes the flags that command execution logic needs: the LBA-mode flag and the device-1 select. A write to the command register stores the command byte and raises a command-valid pulse. It also sets an extended-mode output that reports whether the command is the 48-bit variant.

The pulse comes from a two-state machine. `CMD_IDLE` is the rest state. `CMD_IDLE -> CMD_ISSUE` is taken on a command write. `CMD_ISSUE -> CMD_ISSUE` is taken when another command write follows at once. `CMD_ISSUE -> CMD_IDLE` is taken on any other cycle. Command-valid is high only while the machine is in `CMD_ISSUE`.

Top module: `ata_taskfile_shadow`

## Requirements
- R1: A synchronous reset clears every current and previous byte, the device register and the command byte to zero. After reset, command-valid and the extended-mode output are low.
- R2: Select codes are: 0 data (ignored), 1 feature, 2 sector count, 3 address low, 4 address mid, 5 address high, 6 device, 7 command. A write to one of codes 1 to 5 moves that register's current byte into its previous slot and stores the new byte as current, in the same clock edge. No other register changes.
- R3: The 48-bit address output gives bits [7:0], [15:8] and [23:16] from the current low, mid and high bytes. It gives bits [31:24], [39:32] and [47:40] from the previous low, mid and high bytes.
- R4: The sector count and the feature outputs are each 16 bits wide: the previous byte in [15:8] and the current byte in [7:0].
- R5: The 28-bit address output is formed as {device[3:0], current high, current mid, current low}.
- R6: A write with code 6 stores the device byte. The LBA-mode output equals device bit 6, and the device-1 output equals device bit 4.
- R7: A write with code 7 stores the command byte. Command-valid is high for exactly the one cycle after that write and is low in any cycle after a non-command cycle.
- R8: The extended-mode output equals bit 2 of the last command byte written.
- R9: A cycle with the write strobe low, or a write with select code 0, changes no output.
- R10: Command writes on consecutive cycles keep command-valid high in each following cycle, and each one updates the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 3 | Register select code |
| wr_data | input | 8 | Write data byte |
| lba48 | output | 48 | Assembled 48-bit block address |
| lba28 | output | 28 | Assembled 28-bit block address |
| sect_count | output | 16 | Assembled sector count |
| feature | output | 16 | Assembled feature value |
| dev_reg | output | 8 | Device register byte |
| cmd_byte | output | 8 | Last command byte written |
| cmd_valid | output | 1 | One-cycle pulse after a command write |
| ext_mode | output | 1 | Command asks for 48-bit addressing |
| lba_mode | output | 1 | LBA-mode flag from the device register |
| dev1_sel | output | 1 | Device-1 select from the device register |

## Verification
Properties checked on every cycle cover four things: the shift of the low address byte on each write to it, the command pulse and its byte, the extended-mode flag after a command write, and the stability of all outputs on idle cycles. The bench scenarios are needed for the full byte order of the 48-bit, count and feature fields across a write sequence, and for the 28-bit address built from the device nibble. They also cover the device flag decode, select code 0 being ignored, and reset in the middle of a run clearing all state.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_DATA  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_FEAT  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_COUNT = 3'd2;
    localparam logic [SEL_W-1:0] SEL_LOW   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_MID   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_HIGH  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_DEV   = 3'd6;
    localparam logic [SEL_W-1:0] SEL_CMD   = 3'd7;

    // paired registers occupy consecutive select codes from SEL_FEAT
    localparam int NUM_PAIRS = 5;
    localparam int IDX_FEAT  = 0;
    localparam int IDX_COUNT = 1;
    localparam int IDX_LOW   = 2;
    localparam int IDX_MID   = 3;
    localparam int IDX_HIGH  = 4;

    localparam int DEV_LBA_BIT  = 6;
    localparam int DEV_SEL_BIT  = 4;
    localparam int CMD_EXT_BIT  = 2;

    typedef enum logic [0:0] {
        CMD_IDLE  = 1'b0,
        CMD_ISSUE = 1'b1
    } cmd_state_t;

endpackage

// File: rtl/tf_pair_fifo.sv
module tf_pair_fifo #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            prev <= '0;
        end else if (load) begin
            prev <= cur;
            cur  <= din;
        end
    end

endmodule

// File: rtl/tf_cmd_fsm.sv
module tf_cmd_fsm
    import ata_tf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] cmd_byte,
    output logic         cmd_valid,
    output logic         ext_mode
);

    cmd_state_t state_q;
    cmd_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CMD_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE:  state_d = cmd_wr ? CMD_ISSUE : CMD_IDLE;
            CMD_ISSUE: state_d = cmd_wr ? CMD_ISSUE : CMD_IDLE;
            default:   state_d = CMD_IDLE;
        endcase
    end

    // command byte capture
    always_ff @(posedge clk) begin
        if (rst)         cmd_byte <= '0;
        else if (cmd_wr) cmd_byte <= din;
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        unique case (state_q)
            CMD_IDLE:  cmd_valid = 1'b0;
            CMD_ISSUE: cmd_valid = 1'b1;
            default:   cmd_valid = 1'b0;
        endcase
        ext_mode = cmd_byte[CMD_EXT_BIT];
    end

endmodule

// File: rtl/tf_field_join.sv
module tf_field_join #(
    parameter int W       = 8,
    localparam int WIDE_W = 6 * W,
    localparam int NARW_W = 3 * W + W / 2,
    localparam int PAIR_W = 2 * W
) (
    input  logic [W-1:0]      low_cur,
    input  logic [W-1:0]      low_prev,
    input  logic [W-1:0]      mid_cur,
    input  logic [W-1:0]      mid_prev,
    input  logic [W-1:0]      high_cur,
    input  logic [W-1:0]      high_prev,
    input  logic [W-1:0]      cnt_cur,
    input  logic [W-1:0]      cnt_prev,
    input  logic [W-1:0]      feat_cur,
    input  logic [W-1:0]      feat_prev,
    input  logic [W-1:0]      dev,
    output logic [WIDE_W-1:0] addr_wide,
    output logic [NARW_W-1:0] addr_narrow,
    output logic [PAIR_W-1:0] cnt_word,
    output logic [PAIR_W-1:0] feat_word
);

    always_comb begin
        addr_wide   = {high_prev, mid_prev, low_prev, high_cur, mid_cur, low_cur};
        addr_narrow = {dev[W/2-1:0], high_cur, mid_cur, low_cur};
        cnt_word    = {cnt_prev, cnt_cur};
        feat_word   = {feat_prev, feat_cur};
    end

endmodule

// File: rtl/ata_taskfile_shadow.sv
module ata_taskfile_shadow
    import ata_tf_pkg::*;
#(
    parameter int W       = 8,
    localparam int WIDE_W = 6 * W,
    localparam int NARW_W = 3 * W + W / 2,
    localparam int PAIR_W = 2 * W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [W-1:0]      wr_data,
    output logic [WIDE_W-1:0] lba48,
    output logic [NARW_W-1:0] lba28,
    output logic [PAIR_W-1:0] sect_count,
    output logic [PAIR_W-1:0] feature,
    output logic [W-1:0]      dev_reg,
    output logic [W-1:0]      cmd_byte,
    output logic              cmd_valid,
    output logic              ext_mode,
    output logic              lba_mode,
    output logic              dev1_sel
);

    logic [W-1:0] cur_b  [NUM_PAIRS];
    logic [W-1:0] prev_b [NUM_PAIRS];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic hit;
        assign hit = wr_en && (reg_sel == SEL_W'(g + int'(SEL_FEAT)));
        tf_pair_fifo #(.W(W)) u_fifo (
            .clk  (clk),
            .rst  (rst),
            .load (hit),
            .din  (wr_data),
            .cur  (cur_b[g]),
            .prev (prev_b[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                               dev_reg <= '0;
        else if (wr_en && reg_sel == SEL_DEV)  dev_reg <= wr_data;
    end

    assign lba_mode = dev_reg[DEV_LBA_BIT];
    assign dev1_sel = dev_reg[DEV_SEL_BIT];

    tf_cmd_fsm #(.W(W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (wr_en && reg_sel == SEL_CMD),
        .din       (wr_data),
        .cmd_byte  (cmd_byte),
        .cmd_valid (cmd_valid),
        .ext_mode  (ext_mode)
    );

    tf_field_join #(.W(W)) u_join (
        .low_cur     (cur_b[IDX_LOW]),
        .low_prev    (prev_b[IDX_LOW]),
        .mid_cur     (cur_b[IDX_MID]),
        .mid_prev    (prev_b[IDX_MID]),
        .high_cur    (cur_b[IDX_HIGH]),
        .high_prev   (prev_b[IDX_HIGH]),
        .cnt_cur     (cur_b[IDX_COUNT]),
        .cnt_prev    (prev_b[IDX_COUNT]),
        .feat_cur    (cur_b[IDX_FEAT]),
        .feat_prev   (prev_b[IDX_FEAT]),
        .dev         (dev_reg),
        .addr_wide   (lba48),
        .addr_narrow (lba28),
        .cnt_word    (sect_count),
        .feat_word   (feature)
    );

endmodule

// File: rtl/tf_shadow_chk.sv
module tf_shadow_chk
    import ata_tf_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] reg_sel,
    input logic [W-1:0]     wr_data,
    input logic [6*W-1:0]   lba48,
    input logic [3*W+W/2-1:0] lba28,
    input logic [2*W-1:0]   sect_count,
    input logic [2*W-1:0]   feature,
    input logic [W-1:0]     dev_reg,
    input logic [W-1:0]     cmd_byte,
    input logic             cmd_valid,
    input logic             ext_mode
);

    // R2
    low_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == SEL_LOW) |=>
            (lba48[W-1:0] == $past(wr_data)) && (lba48[4*W-1:3*W] == $past(lba48[W-1:0])));

    // R7
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == SEL_CMD) |=> (cmd_valid && cmd_byte == $past(wr_data)));

    // R7
    cmd_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_sel == SEL_CMD) |=> !cmd_valid);

    // R8
    ext_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == SEL_CMD) |=> (ext_mode == $past(wr_data[CMD_EXT_BIT])));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || reg_sel == SEL_DATA) |=>
            ($stable(lba48) && $stable(lba28) && $stable(sect_count) && $stable(feature)
             && $stable(dev_reg) && $stable(cmd_byte)));

    // R5
    narrow_low_chk: assert property (@(posedge clk) disable iff (rst)
        lba28[3*W-1:0] == lba48[3*W-1:0]);

endmodule

bind ata_taskfile_shadow tf_shadow_chk #(.W(W)) u_shadow_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .lba48      (lba48),
    .lba28      (lba28),
    .sect_count (sect_count),
    .feature    (feature),
    .dev_reg    (dev_reg),
    .cmd_byte   (cmd_byte),
    .cmd_valid  (cmd_valid),
    .ext_mode   (ext_mode)
);

// File: tb/tb_ata_taskfile_shadow.sv
module tb_ata_taskfile_shadow;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [47:0] lba48;
    logic [27:0] lba28;
    logic [15:0] sect_count;
    logic [15:0] feature;
    logic [7:0]  dev_reg;
    logic [7:0]  cmd_byte;
    logic        cmd_valid;
    logic        ext_mode;
    logic        lba_mode;
    logic        dev1_sel;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ata_taskfile_shadow dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .reg_sel    (reg_sel),
        .wr_data    (wr_data),
        .lba48      (lba48),
        .lba28      (lba28),
        .sect_count (sect_count),
        .feature    (feature),
        .dev_reg    (dev_reg),
        .cmd_byte   (cmd_byte),
        .cmd_valid  (cmd_valid),
        .ext_mode   (ext_mode),
        .lba_mode   (lba_mode),
        .dev1_sel   (dev1_sel)
    );

    typedef struct {
        logic [127:0] exp;
        string        tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    // reference model, indexed by select code
    logic [7:0] cur_m  [8];
    logic [7:0] prev_m [8];
    logic [7:0] dev_m;
    logic [7:0] cmd_m;
    logic       cv_m;

    function automatic logic [127:0] model_vec();
        logic [47:0] a48;
        logic [27:0] a28;
        a48 = {prev_m[5], prev_m[4], prev_m[3], cur_m[5], cur_m[4], cur_m[3]};
        a28 = {dev_m[3:0], cur_m[5], cur_m[4], cur_m[3]};
        return {a48, a28, prev_m[2], cur_m[2], prev_m[1], cur_m[1], dev_m, cmd_m,
                cv_m, cmd_m[2], dev_m[6], dev_m[4]};
    endfunction

    function automatic logic [127:0] dut_vec();
        return {lba48, lba28, sect_count, feature, dev_reg, cmd_byte,
                cmd_valid, ext_mode, lba_mode, dev1_sel};
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 8; i++) begin
            cur_m[i]  = 8'd0;
            prev_m[i] = 8'd0;
        end
        dev_m = 8'd0;
        cmd_m = 8'd0;
        cv_m  = 1'b0;
    endtask

    task automatic compare(input logic [127:0] exp, input string tag);
        logic [127:0] act;
        act = dut_vec();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one bus cycle, then push the expected outputs
    task automatic drive(input logic en, input logic [2:0] sel,
                         input logic [7:0] data, input string tag);
        item_t it;
        @(negedge clk);
        wr_en   = en;
        reg_sel = sel;
        wr_data = data;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        cv_m  = 1'b0;
        if (en) begin
            if (sel >= 3'd1 && sel <= 3'd5) begin
                prev_m[sel] = cur_m[sel];
                cur_m[sel]  = data;
            end else if (sel == 3'd6) begin
                dev_m = data;
            end else if (sel == 3'd7) begin
                cmd_m = data;
                cv_m  = 1'b1;
            end
        end
        it.exp = model_vec();
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare one cycle's outputs per queued item
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            compare(it.exp, it.tag);
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        clear_model();
        @(negedge clk);
        compare(128'd0, tag);
    endtask

    initial begin
        clear_model();
        do_reset("R1 reset state");

        // R3 48-bit address from three paired registers
        drive(1, 3'd3, 8'h56, "R2 low first");
        drive(1, 3'd3, 8'hCD, "R2 low shift");
        drive(1, 3'd4, 8'h34, "R2 mid first");
        drive(1, 3'd4, 8'hAB, "R2 mid shift");
        drive(1, 3'd5, 8'h12, "R3 high first");
        drive(1, 3'd5, 8'h78, "R3 address 0x12345678ABCD");
        // R4 count and feature pairs
        drive(1, 3'd2, 8'h01, "R4 count first");
        drive(1, 3'd2, 8'h02, "R4 count 0x0102");
        drive(1, 3'd1, 8'h11, "R4 feature first");
        drive(1, 3'd1, 8'h22, "R4 feature 0x1122");
        // R5 R6 device register
        drive(1, 3'd6, 8'hE5, "R5 R6 device lba nibble 5");
        drive(1, 3'd6, 8'hF3, "R6 device1 select");
        drive(1, 3'd6, 8'hA0, "R6 flags clear");
        // R7 R8 command pulse and ext flag
        drive(1, 3'd7, 8'h24, "R7 R8 extended command");
        drive(0, 3'd0, 8'h00, "R7 pulse ends");
        drive(1, 3'd7, 8'h20, "R10 first of pair");
        drive(1, 3'd7, 8'h30, "R10 second of pair");
        drive(0, 3'd0, 8'h00, "R10 pulse ends");
        // R9 ignored cycles
        drive(0, 3'd3, 8'hFF, "R9 strobe low");
        drive(1, 3'd0, 8'hEE, "R9 data select ignored");
        drive(0, 3'd7, 8'h34, "R9 command strobe low");
        // R2 third write drops the oldest byte
        drive(1, 3'd3, 8'h9A, "R2 low third write");
        drive(1, 3'd5, 8'h00, "R3 high zero shift");
        repeat (3) @(negedge clk);

        do_reset("R1 reset mid run");
        drive(1, 3'd4, 8'h5C, "R2 mid after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule